// File: doc/BRIEF.md
# Data Clock Burst Generator

This block produces a programmed number of single-cycle clock-enable pulses for a configuration data path. A host writes a burst length into the length register. The block then raises its enable output for exactly that many consecutive cycles. When the last pulse goes out, it latches a sticky completion flag.

The host polls the completion flag through the status register and clears it by writing a 1 to bit 0. Bursts may be very short, a few cycles, or long, tens of thousands of cycles. A new length written at any time abandons the current burst and starts over. The length register reads back the number of pulses still to be emitted.

Register access uses a simple 32-bit bus. A write is taken in the cycle where the write strobe is high. Read data is registered and appears one cycle after the read strobe.

Top module: `dclk_burst`

## Requirements
- R1: The length register sits at byte offset 0x8 and the status register at 0xC. Status bit 0 is the completion flag and its other bits read 0. A read at any other offset returns 0. Read data is valid in the cycle after the read strobe.
- R2: Writing a non-zero length N drives `dclk_en_o` high for exactly N consecutive cycles. The first pulse is in the second cycle after the write cycle, and each pulse lowers the remaining count by one.
- R3: The completion flag sets on the clock edge that raises the last pulse. It stays set until it is cleared or a new length is written.
- R4: A status write with bit 0 set clears the completion flag. A status write with bit 0 clear leaves the flag unchanged.
- R5: Writing a length of 0 sets the completion flag at once and emits no pulses.
- R6: Writing the length register during a burst restarts it with the new length. The restart clears the completion flag and produces no pulse in the cycle after that write.
- R7: If a clear write lands on the same edge as the last pulse, the completion flag is left set.
- R8: Only the low CNT_W bits of a written length are used. With the default width, lengths from 1 to 65535, including 0x5000, run in full.
- R9: A read of the length register returns the number of pulses not yet emitted.
- R10: After reset, `dclk_en_o` is low, the completion flag is clear and the remaining count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | 32 | Registered read data |
| dclk_en_o | output | 1 | One-cycle data-clock enable pulse |

## Verification
The bench builds the block with its default 8-bit offsets and 16-bit counter. At this size the longest bursts, 0x5000 and 65535 pulses, run to completion inside the cycle budget. Every length from 0 to 40 is swept with a cycle-exact pulse pattern. The one-pulse and zero-length corners, upper-bit truncation, mid-burst restart and the clear-versus-completion collision are each hit at a known edge.

// File: rtl/dclk_burst_pkg.sv
package dclk_burst_pkg;
  localparam int unsigned OFS_LEN  = 32'h8;
  localparam int unsigned OFS_STAT = 32'hC;
  localparam int unsigned DATA_W   = 32;
endpackage

// File: rtl/dclk_reg_decode.sv
module dclk_reg_decode #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CNT_W-1:0]  remain,
  input  logic              done,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic              clr,
  output logic [31:0]       rd_data
);
  import dclk_burst_pkg::*;
  localparam logic [ADDR_W-1:0] A_LEN  = ADDR_W'(OFS_LEN);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

  assign load     = wr_en && (wr_addr == A_LEN);
  assign load_val = wr_data[CNT_W-1:0];
  assign clr      = wr_en && (wr_addr == A_STAT) && wr_data[0];

  logic [31:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (rd_addr == A_LEN)       rd_next = 32'(remain);
    else if (rd_addr == A_STAT) rd_next = {31'b0, done};
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end
endmodule

// File: rtl/dclk_burst_ctr.sv
module dclk_burst_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] remain,
  output logic             pulse,
  output logic             finish
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign finish = !load && (remain == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
      pulse  <= 1'b0;
    end else if (load) begin
      remain <= load_val;
      pulse  <= 1'b0;
    end else if (remain != '0) begin
      remain <= remain - ONE;
      pulse  <= 1'b1;
    end else begin
      pulse  <= 1'b0;
    end
  end
endmodule

// File: rtl/dclk_done_flag.sv
module dclk_done_flag #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             finish,
  input  logic             clr,
  output logic             done
);
  always_ff @(posedge clk) begin
    if (rst)         done <= 1'b0;
    else if (load)   done <= (load_val == '0);
    else if (finish) done <= 1'b1;
    else if (clr)    done <= 1'b0;
  end
endmodule

// File: rtl/dclk_burst.sv
module dclk_burst #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              dclk_en_o
);
  logic             load, clr, finish, done;
  logic [CNT_W-1:0] load_val, remain;

  dclk_reg_decode #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dec (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .remain(remain), .done(done),
    .load(load), .load_val(load_val), .clr(clr), .rd_data(rd_data)
  );

  dclk_burst_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val),
    .remain(remain), .pulse(dclk_en_o), .finish(finish)
  );

  dclk_done_flag #(.CNT_W(CNT_W)) u_flag (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val),
    .finish(finish), .clr(clr), .done(done)
  );
endmodule

// File: rtl/dclk_burst_chk.sv
module dclk_burst_chk #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic              dclk_en_o,
  input logic [CNT_W-1:0]  remain,
  input logic              done
);
  import dclk_burst_pkg::*;
  logic is_len, is_clr;
  assign is_len = wr_en && (wr_addr == ADDR_W'(OFS_LEN));
  assign is_clr = wr_en && (wr_addr == ADDR_W'(OFS_STAT)) && wr_data[0];

  p_count_down_r2: assert property (@(posedge clk) disable iff (rst)
    (!is_len && remain != '0) |=> (dclk_en_o && remain == $past(remain) - CNT_W'(1)));
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (!is_len && remain == '0) |=> !dclk_en_o);
  p_done_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (done && !is_len && !is_clr) |=> done);
  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (is_clr && remain != CNT_W'(1)) |=> !done);
  p_zero_len_r5: assert property (@(posedge clk) disable iff (rst)
    (is_len && wr_data[CNT_W-1:0] == '0) |=> (done && !dclk_en_o));
  p_restart_r6: assert property (@(posedge clk) disable iff (rst)
    (is_len && wr_data[CNT_W-1:0] != '0) |=> (!done && !dclk_en_o));
  p_collision_r7: assert property (@(posedge clk) disable iff (rst)
    (is_clr && remain == CNT_W'(1)) |=> done);
  p_reset_r10: assert property (@(posedge clk)
    rst |=> (!dclk_en_o && !done && remain == '0));
endmodule

bind dclk_burst dclk_burst_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .dclk_en_o(dclk_en_o), .remain(remain), .done(done)
);

// File: tb/dclk_burst_test.sv
module dclk_burst_test;
  localparam int ADDR_W = 8;
  localparam int CNT_W  = 16;
  localparam logic [ADDR_W-1:0] A_LEN  = 8'h08;
  localparam logic [ADDR_W-1:0] A_STAT = 8'h0C;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic dclk_en_o;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  dclk_burst #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .dclk_en_o(dclk_en_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Caller is at a falling edge; the write is taken on the next rising edge.
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  // Write length, then compare dclk_en_o with the expected pattern cycle by cycle.
  task automatic burst(input string req, input logic [31:0] len, input int expn);
    int bad = 0;
    logic [31:0] s;
    wr(A_LEN, len);
    for (int i = 1; i <= expn + 3; i++) begin
      @(negedge clk);
      if (dclk_en_o !== (i <= expn)) bad++;
    end
    check(req, bad, 0);
    rd(A_STAT, s);
    check(req, s, 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check("R10 pulse", {31'b0, dclk_en_o}, 0);
    rd(A_STAT, v); check("R10 done", v, 0);
    rd(A_LEN, v);  check("R10 remain", v, 0);
    // R1 unmapped offsets read zero
    rd(8'h00, v); check("R1 ofs0", v, 0);
    rd(8'h04, v); check("R1 ofs4", v, 0);
    // R2 R3 sweep of lengths
    for (int n = 1; n <= 40; n++) begin
      burst("R2 R3 sweep", n, n);
      wr(A_STAT, 32'h1);
    end
    // R4 clear behaviour
    burst("R3 set", 5, 5);
    wr(A_STAT, 32'h0); rd(A_STAT, v); check("R4 no-clear", v, 1);
    wr(A_STAT, 32'h1); rd(A_STAT, v); check("R4 clear", v, 0);
    // R5 zero length
    burst("R5 zero", 0, 0);
    // R9 remaining readback: read taken on the edge after the write
    wr(A_LEN, 32'd10);
    rd(A_LEN, v); check("R9 remain", v, 10);
    rd(A_LEN, v); check("R9 remain dec", v, 9);
    // R6 restart mid-burst clears done, new length runs in full
    burst("R6 restart", 6, 6);
    wr(A_LEN, 32'd10);
    repeat (3) @(negedge clk);
    rd(A_STAT, v); check("R6 done clear", v, 0);
    burst("R6 restart", 6, 6);
    // R7 clear on the finishing edge
    wr(A_STAT, 32'h1);
    wr(A_LEN, 32'd3);
    repeat (2) @(negedge clk);
    wr(A_STAT, 32'h1);
    rd(A_STAT, v); check("R7 collision", v, 1);
    wr(A_STAT, 32'h1); rd(A_STAT, v); check("R7 later clear", v, 0);
    // R8 upper bits ignored, long bursts
    burst("R8 truncate", 32'h0001_0003, 3);
    burst("R8 long 0x5000", 32'h5000, 32'h5000);
    burst("R8 max", 32'hFFFF, 65535);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule